// File: doc/BRIEF.md
# Smart Card Contact Activation and Cold Reset Sequencer

This block sits in the interface-device side of a contact smart card reader. When a card is detected and software requests a session, it powers the contacts up in a fixed order. It starts the card clock and holds the card reset line low for a counted window. If the card does not begin its answer in that window, it raises reset and waits for a second counted window. If the card stays silent, or starts its answer too early, or is pulled out, or the exchange is aborted, the block powers the contacts down in a fixed order.

All timing is counted in cycles of `clk`, which is taken to run at the card clock rate. Each power-up and power-down step lasts `STEP_CYC` cycles so that the supplies can settle. Each reset-level window lasts `HOLD_CYC` cycles. An answer is accepted only at `MIN_ANS` or more cycles into a window. Once an answer is accepted, the reset line keeps the level it had, and `sess_ready` stays high until the contacts are deactivated.

Top module: `sc_reset_seq`

## Requirements
- R1: After a synchronous reset (`rst` high), card_rst, card_clk_en, card_vpp_en and card_vcc_en are 0, card_io_low is 1, and sess_ready, err_timeout and err_early are 0.
- R2: A start_req taken while card_present is 0 has no effect. All contact outputs keep their deactivated values.
- R3: A start_req with card_present high, sampled at an edge while idle, turns card_vcc_en on at that edge. card_io_low falls `STEP_CYC` cycles later. card_vpp_en rises `STEP_CYC` cycles after that. card_clk_en rises `STEP_CYC` cycles after that. card_rst stays 0 throughout.
- R4: Counting from the edge that enables the clock, card_rst stays 0 for exactly `HOLD_CYC` cycles and then rises if no answer has been seen.
- R5: An answer_start sampled at cycle offset k of the reset-low window, with `MIN_ANS` <= k < `HOLD_CYC`, makes sess_ready 1 at that edge, and card_rst stays 0.
- R6: An answer_start sampled at offset k of the reset-high window, with `MIN_ANS` <= k < `HOLD_CYC`, makes sess_ready 1 at that edge, and card_rst stays 1.
- R7: If no answer arrives in the `HOLD_CYC` cycles of the reset-high window, err_timeout rises and card_rst falls at the same edge. Deactivation then begins.
- R8: An answer_start at offset k < `MIN_ANS` of either window raises err_early, drops card_rst, and begins deactivation.
- R9: Deactivation opens by driving card_rst to 0. Each later step comes `STEP_CYC` cycles after the previous one, in this order: card_clk_en 0, card_vpp_en 0, card_io_low 1, card_vcc_en 0. After `STEP_CYC` more cycles the block is idle.
- R10: A card_present low or an abort_req sampled in any activation, window or session state drops card_rst at that edge. All contacts are off `5*STEP_CYC` cycles later.
- R11: During a session, answer_start and start_req have no effect: sess_ready stays 1 and card_rst keeps its level.
- R12: A new accepted start clears err_timeout and err_early at the edge that enables VCC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card-rate clock for all counting |
| rst | input | 1 | Synchronous active-high reset |
| card_present | input | 1 | Card detected in the slot |
| start_req | input | 1 | Request to activate and cold-reset the card |
| abort_req | input | 1 | Request to end the session and deactivate |
| answer_start | input | 1 | Receiver saw the leading edge of the first answer character |
| card_rst | output | 1 | Card reset contact level |
| card_vcc_en | output | 1 | Card supply enable |
| card_vpp_en | output | 1 | Programming supply at idle level |
| card_clk_en | output | 1 | Card clock gate |
| card_io_low | output | 1 | 1: I/O contact driven low; 0: I/O in reception |
| sess_ready | output | 1 | Answer accepted, session running |
| err_timeout | output | 1 | No answer in either reset window |
| err_early | output | 1 | Answer began before the minimum offset |

## Verification
The bench builds the block with `STEP_CYC`=3, `HOLD_CYC`=20 and `MIN_ANS`=5. With these values it can try an answer at every cycle offset of both the reset-low and reset-high windows, so both sides of the early-answer bound and the last accepted cycle before each timeout are covered. It also removes the card at every cycle from the start request to the final timeout edge. This covers the removal path from every activation step, from both windows, and at the edge where removal and timeout coincide.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACT_VCC,
        ST_ACT_IO,
        ST_ACT_VPP,
        ST_WAIT_LO,
        ST_WAIT_HI,
        ST_SESSION,
        ST_DEA_RST,
        ST_DEA_CLK,
        ST_DEA_VPP,
        ST_DEA_IO,
        ST_DEA_VCC
    } seq_state_e;

    typedef struct packed {
        logic rst;
        logic clk;
        logic vpp;
        logic io_low;
        logic vcc;
    } pin_set_t;

    localparam pin_set_t PINS_OFF = '{rst: 1'b0, clk: 1'b0, vpp: 1'b0, io_low: 1'b1, vcc: 1'b0};

    // States in which removal or abort forces deactivation
    function automatic logic is_live(seq_state_e s);
        return (s == ST_ACT_VCC) || (s == ST_ACT_IO) || (s == ST_ACT_VPP) ||
               (s == ST_WAIT_LO) || (s == ST_WAIT_HI) || (s == ST_SESSION);
    endfunction

    // Contact change applied on entering a state; others keep their level
    function automatic pin_set_t apply_step(pin_set_t cur, seq_state_e tgt);
        pin_set_t nxt;
        nxt = cur;
        case (tgt)
            ST_ACT_VCC: nxt.vcc    = 1'b1;
            ST_ACT_IO:  nxt.io_low = 1'b0;
            ST_ACT_VPP: nxt.vpp    = 1'b1;
            ST_WAIT_LO: nxt.clk    = 1'b1;
            ST_WAIT_HI: nxt.rst    = 1'b1;
            ST_DEA_RST: nxt.rst    = 1'b0;
            ST_DEA_CLK: nxt.clk    = 1'b0;
            ST_DEA_VPP: nxt.vpp    = 1'b0;
            ST_DEA_IO:  nxt.io_low = 1'b1;
            ST_DEA_VCC: nxt.vcc    = 1'b0;
            default:    nxt        = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/sc_cycle_cnt.sv
module sc_cycle_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (q != TOP) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/sc_pin_reg.sv
module sc_pin_reg
    import sc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  seq_state_e tgt,
    output pin_set_t   pins
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pins <= PINS_OFF;
        end else if (load) begin
            pins <= apply_step(pins, tgt);
        end
    end
endmodule

// File: rtl/sc_reset_seq.sv
module sc_reset_seq
    import sc_seq_pkg::*;
#(
    parameter int STEP_CYC = 1000,
    parameter int HOLD_CYC = 40000,
    parameter int MIN_ANS  = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic card_present,
    input  logic start_req,
    input  logic abort_req,
    input  logic answer_start,
    output logic card_rst,
    output logic card_vcc_en,
    output logic card_vpp_en,
    output logic card_clk_en,
    output logic card_io_low,
    output logic sess_ready,
    output logic err_timeout,
    output logic err_early
);
    localparam int LONGEST = (STEP_CYC > HOLD_CYC) ? STEP_CYC : HOLD_CYC;
    localparam int CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] STEP_LAST = CW'(STEP_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] ANS_MIN   = CW'(MIN_ANS);

    seq_state_e    st_q, st_d;
    logic [CW-1:0] cnt;
    logic          change;
    logic          step_last, win_last;
    logic          ev_early, ev_tout, ev_start;
    pin_set_t      pins;

    assign change    = (st_d != st_q);
    assign step_last = (cnt == STEP_LAST);
    assign win_last  = (cnt == HOLD_LAST);

    sc_cycle_cnt #(.W(CW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (change),
        .q   (cnt)
    );

    sc_pin_reg u_pins (
        .clk  (clk),
        .rst  (rst),
        .load (change),
        .tgt  (st_d),
        .pins (pins)
    );

    always_comb begin
        st_d     = st_q;
        ev_early = 1'b0;
        ev_tout  = 1'b0;
        ev_start = 1'b0;
        if (is_live(st_q) && (!card_present || abort_req)) begin
            st_d = ST_DEA_RST;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_req && card_present) begin
                        st_d     = ST_ACT_VCC;
                        ev_start = 1'b1;
                    end
                end
                ST_ACT_VCC: if (step_last) st_d = ST_ACT_IO;
                ST_ACT_IO:  if (step_last) st_d = ST_ACT_VPP;
                ST_ACT_VPP: if (step_last) st_d = ST_WAIT_LO;
                ST_WAIT_LO, ST_WAIT_HI: begin
                    if (answer_start) begin
                        if (cnt < ANS_MIN) begin
                            ev_early = 1'b1;
                            st_d     = ST_DEA_RST;
                        end else begin
                            st_d = ST_SESSION;
                        end
                    end else if (win_last) begin
                        if (st_q == ST_WAIT_LO) begin
                            st_d = ST_WAIT_HI;
                        end else begin
                            ev_tout = 1'b1;
                            st_d    = ST_DEA_RST;
                        end
                    end
                end
                ST_SESSION: st_d = ST_SESSION;
                ST_DEA_RST: if (step_last) st_d = ST_DEA_CLK;
                ST_DEA_CLK: if (step_last) st_d = ST_DEA_VPP;
                ST_DEA_VPP: if (step_last) st_d = ST_DEA_IO;
                ST_DEA_IO:  if (step_last) st_d = ST_DEA_VCC;
                ST_DEA_VCC: if (step_last) st_d = ST_IDLE;
                default:    st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            err_timeout <= 1'b0;
            err_early   <= 1'b0;
        end else begin
            st_q <= st_d;
            if (ev_start) begin
                err_timeout <= 1'b0;
                err_early   <= 1'b0;
            end
            if (ev_tout) err_timeout <= 1'b1;
            if (ev_early) err_early <= 1'b1;
        end
    end

    assign card_rst    = pins.rst;
    assign card_clk_en = pins.clk;
    assign card_vpp_en = pins.vpp;
    assign card_io_low = pins.io_low;
    assign card_vcc_en = pins.vcc;
    assign sess_ready  = (st_q == ST_SESSION);

endmodule

// File: rtl/sc_reset_seq_chk.sv
module sc_reset_seq_chk (
    input logic clk,
    input logic rst,
    input logic card_present,
    input logic start_req,
    input logic card_rst,
    input logic card_vcc_en,
    input logic card_vpp_en,
    input logic card_clk_en,
    input logic card_io_low,
    input logic sess_ready,
    input logic err_timeout
);
    // R3: the clock runs only with supplies up and I/O receiving
    assert_clk_needs_power_R3: assert property (@(posedge clk) disable iff (rst)
        card_clk_en |-> (card_vcc_en && card_vpp_en && !card_io_low));

    // R4: reset is raised only while the card clock runs
    assert_rst_needs_clk_R4: assert property (@(posedge clk) disable iff (rst)
        card_rst |-> card_clk_en);

    // R2: supply comes up only after a start with a card present
    assert_power_gate_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(card_vcc_en) |-> $past(card_present && start_req));

    // R10: removal while clocked drops reset at the next edge
    assert_removal_drops_rst_R10: assert property (@(posedge clk) disable iff (rst)
        (card_clk_en && !card_present) |=> !card_rst);

    // R9: supply is removed last
    assert_vcc_last_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(card_vcc_en) |-> (card_io_low && !card_vpp_en && !card_clk_en && !card_rst));

    // R11: reset level is frozen during a session
    assert_session_rst_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (sess_ready && $past(sess_ready)) |-> (card_rst == $past(card_rst)));

    // R7: timeout flag rises together with reset falling
    assert_timeout_drops_rst_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_timeout) |-> (!card_rst && $past(card_rst)));
endmodule

bind sc_reset_seq sc_reset_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .card_present (card_present),
    .start_req    (start_req),
    .card_rst     (card_rst),
    .card_vcc_en  (card_vcc_en),
    .card_vpp_en  (card_vpp_en),
    .card_clk_en  (card_clk_en),
    .card_io_low  (card_io_low),
    .sess_ready   (sess_ready),
    .err_timeout  (err_timeout)
);

// File: tb/sim_sc_reset_seq.sv
`timescale 1ns/1ps
module sim_sc_reset_seq;
    localparam int STEP = 3;
    localparam int HOLD = 20;
    localparam int MINA = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic card_present = 1'b0;
    logic start_req = 1'b0;
    logic abort_req = 1'b0;
    logic answer_start = 1'b0;
    logic card_rst, card_vcc_en, card_vpp_en, card_clk_en, card_io_low;
    logic sess_ready, err_timeout, err_early;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sc_reset_seq #(.STEP_CYC(STEP), .HOLD_CYC(HOLD), .MIN_ANS(MINA)) u0 (
        .clk(clk), .rst(rst), .card_present(card_present), .start_req(start_req),
        .abort_req(abort_req), .answer_start(answer_start), .card_rst(card_rst),
        .card_vcc_en(card_vcc_en), .card_vpp_en(card_vpp_en), .card_clk_en(card_clk_en),
        .card_io_low(card_io_low), .sess_ready(sess_ready), .err_timeout(err_timeout),
        .err_early(err_early)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // packed as {rst, clk, vpp, io_low, vcc}
    task automatic check_pins(input string tag, input logic [4:0] exp);
        check(tag, int'({card_rst, card_clk_en, card_vpp_en, card_io_low, card_vcc_en}), int'(exp));
    endtask

    task automatic activate();
        card_present = 1'b1;
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        check_pins("R3 vcc on", 5'b00011);
        check("R12 errors cleared", int'({err_timeout, err_early}), 0);
        ticks(STEP - 1);
        check_pins("R3 vcc step held", 5'b00011);
        tick();
        check_pins("R3 io receive", 5'b00001);
        ticks(STEP);
        check_pins("R3 vpp on", 5'b00101);
        ticks(STEP);
        check_pins("R3 clk on", 5'b01101);
    endtask

    // entered the first deactivation state from a fully powered state
    task automatic deact_order();
        check_pins("R9 rst low first", 5'b01101);
        ticks(STEP);
        check_pins("R9 clk off", 5'b00101);
        ticks(STEP);
        check_pins("R9 vpp off", 5'b00001);
        ticks(STEP);
        check_pins("R9 io low", 5'b00011);
        ticks(STEP);
        check_pins("R9 vcc off", 5'b00010);
        ticks(STEP);
        check_pins("R9 idle", 5'b00010);
    endtask

    task automatic answer_pulse();
        answer_start = 1'b1;
        tick();
        answer_start = 1'b0;
    endtask

    task automatic abort_now();
        abort_req = 1'b1;
        tick();
        abort_req = 1'b0;
    endtask

    initial begin
        ticks(3);
        rst = 1'b0;
        check_pins("R1 reset pins", 5'b00010);
        check("R1 reset flags", int'({sess_ready, err_timeout, err_early}), 0);

        // R2: start without card
        card_present = 1'b0;
        start_req = 1'b1;
        ticks(4);
        start_req = 1'b0;
        check_pins("R2 no card no power", 5'b00010);

        // R4: reset-low window length
        activate();
        ticks(HOLD - 1);
        check("R4 rst low before window end", int'(card_rst), 0);
        tick();
        check_pins("R4 rst raised", 5'b11101);
        abort_now();
        deact_order();

        // R5 / R8: answer at each offset of the reset-low window
        for (int k = 0; k < HOLD; k++) begin
            activate();
            ticks(k);
            answer_pulse();
            if (k < MINA) begin
                check("R8 early flag low window", int'(err_early), 1);
                check("R8 no session", int'(sess_ready), 0);
                deact_order();
            end else begin
                check("R5 session low", int'(sess_ready), 1);
                check("R5 rst stays low", int'(card_rst), 0);
                answer_pulse();
                start_req = 1'b1;
                tick();
                start_req = 1'b0;
                check("R11 session kept", int'(sess_ready), 1);
                check_pins("R11 pins kept low", 5'b01101);
                abort_now();
                check("R10 abort ends session", int'(sess_ready), 0);
                deact_order();
            end
        end

        // R6 / R8: answer at each offset of the reset-high window
        for (int k = 0; k < HOLD; k++) begin
            activate();
            ticks(HOLD + k);
            answer_pulse();
            if (k < MINA) begin
                check("R8 early flag high window", int'(err_early), 1);
                deact_order();
            end else begin
                check("R6 session high", int'(sess_ready), 1);
                check("R6 rst stays high", int'(card_rst), 1);
                answer_pulse();
                ticks(2);
                check_pins("R11 pins kept high", 5'b11101);
                abort_now();
                deact_order();
            end
        end

        // R7: timeout, then R12 clears it
        activate();
        ticks(HOLD);
        ticks(HOLD - 1);
        check("R7 no timeout yet", int'(err_timeout), 0);
        check("R7 rst high before end", int'(card_rst), 1);
        tick();
        check("R7 timeout flag", int'(err_timeout), 1);
        deact_order();
        activate();
        check("R12 timeout cleared", int'(err_timeout), 0);
        abort_now();
        deact_order();

        // R10: removal at every cycle up to the final timeout edge
        for (int s = 0; s < 3 * STEP + 2 * HOLD; s++) begin
            card_present = 1'b1;
            start_req = 1'b1;
            tick();
            start_req = 1'b0;
            ticks(s);
            card_present = 1'b0;
            tick();
            check("R10 removal drops rst", int'(card_rst), 0);
            check("R10 no session", int'(sess_ready), 0);
            ticks(5 * STEP);
            check_pins("R10 all off after removal", 5'b00010);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule